// File: doc/BRIEF.md
# Serial Timing Receiver Lock Supervisor

This block watches the sync-error flag of a serial timing receiver and decides when the receiver should be told to try to acquire lock again. When the flag has stayed high for a minimum number of local-clock cycles, the block drives an acknowledge pulse of fixed width toward the receiver, which starts a new lock attempt. If the error is still present afterwards, the block waits the same minimum time again before it pulses once more. A short error burst never triggers a retry, and any gap in the error restarts the timing from zero.

The sync-error flag is also looped straight through to a sync-lost output. This lets the upstream hub see the link state without any added delay. All logic runs from a free-running local clock. The receiver's recovered clock is never used, because it stops whenever lock is lost. The flag is asynchronous to the local clock, so it passes through a two-stage synchronizer before it is counted.

Top module: `lock_supervisor`

## Requirements
- R1: `sync_lost_o` equals `sync_err_i` at all times, with no register in the path, including while reset is asserted.
- R2: `sync_err_i` passes through exactly two flip-flops before it is counted. The counter acts on the sample taken two clock edges earlier.
- R3: An error held for fewer than `MIN_ERR_CYCLES` consecutive clock samples produces no acknowledge pulse.
- R4: An error held for at least `MIN_ERR_CYCLES` consecutive samples raises `ack_o`. It is first seen high right after clock edge `MIN_ERR_CYCLES + 2`, where edge 1 is the first edge that samples the error high.
- R5: Every acknowledge pulse is high for exactly `ACK_CYCLES` cycles, and it completes even if the error clears during the pulse.
- R6: While the error persists, successive pulses are separated by exactly `MIN_ERR_CYCLES` low cycles. This is the holdoff, so rises are `ACK_CYCLES + MIN_ERR_CYCLES` cycles apart.
- R7: A single low sample of the synchronized error clears the duration count. A later error counts again from zero.
- R8: While `rst_ni` is low, and in the first cycle after it is released, `ack_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_err_i | input | 1 | Sync-error flag from the receiver (asynchronous) |
| ack_o | output | 1 | Lock-attempt request pulse to the receiver |
| sync_lost_o | output | 1 | Sync-error looped toward the upstream hub |

## Verification
The properties assume that the synchronized error is a clean level that the counter sees once per local-clock cycle. They also assume that reset is applied before any pulse is expected.

The stimulus changes `sync_err_i` only at falling clock edges, so every level is sampled on whole cycles and the two-stage latency is deterministic. Bursts are separated by low gaps longer than one pulse plus one holdoff, so each burst's expected pulses depend on that burst alone. The exception is the one-cycle gap used on purpose to show that the count is cleared.

// File: rtl/lsv_pkg.sv
package lsv_pkg;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_PULSE = 1'b1
    } lsv_state_e;

endpackage

// File: rtl/lsv_sync.sv
module lsv_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_reg_t;

    sync_reg_t sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb begin
                sync_d       = sync_q;
                sync_d.chain = async_i;
            end
        end else begin : g_many
            always_comb begin
                sync_d       = sync_q;
                sync_d.chain = {sync_q.chain[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.chain[STAGES-1];

endmodule

// File: rtl/lsv_fsm.sv
module lsv_fsm
    import lsv_pkg::*;
#(
    parameter int unsigned MIN_ERR_CYCLES = 20,
    parameter int unsigned ACK_CYCLES     = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic err_i,
    output logic ack_o
);

    localparam int unsigned CNT_MAX = (MIN_ERR_CYCLES > ACK_CYCLES) ? MIN_ERR_CYCLES : ACK_CYCLES;
    localparam int unsigned CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] LAST_ERR = CNT_W'(MIN_ERR_CYCLES - 1);
    localparam logic [CNT_W-1:0] LAST_ACK = CNT_W'(ACK_CYCLES - 1);

    typedef struct packed {
        lsv_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_reg_t;

    fsm_reg_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_COUNT: begin
                // Counting the error duration; after a pulse this same phase is the holdoff.
                if (!err_i) begin
                    fsm_d.cnt = '0;
                end else if (fsm_q.cnt == LAST_ERR) begin
                    fsm_d.st  = ST_PULSE;
                    fsm_d.cnt = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_PULSE: begin
                // The pulse always runs to full width, independent of the error level.
                if (fsm_q.cnt == LAST_ACK) begin
                    fsm_d.st  = ST_COUNT;
                    fsm_d.cnt = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            default: begin
                fsm_d.st  = ST_COUNT;
                fsm_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q.st  <= ST_COUNT;
            fsm_q.cnt <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign ack_o = (fsm_q.st == ST_PULSE);

endmodule

// File: rtl/lock_supervisor.sv
module lock_supervisor #(
    parameter int unsigned MIN_ERR_CYCLES = 20,
    parameter int unsigned ACK_CYCLES     = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_err_i,
    output logic ack_o,
    output logic sync_lost_o
);

    localparam int unsigned SYNC_STAGES = 2;

    logic err_s;

    lsv_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (sync_err_i),
        .sync_o  (err_s)
    );

    lsv_fsm #(
        .MIN_ERR_CYCLES (MIN_ERR_CYCLES),
        .ACK_CYCLES     (ACK_CYCLES)
    ) u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .err_i  (err_s),
        .ack_o  (ack_o)
    );

    // Loop-through toward the hub, deliberately unregistered.
    assign sync_lost_o = sync_err_i;

endmodule

// File: rtl/lsv_checker.sv
module lsv_checker #(
    parameter int unsigned MIN_ERR_CYCLES = 20,
    parameter int unsigned ACK_CYCLES     = 3
) (
    input logic clk_i,
    input logic rst_ni,
    input logic err_s,
    input logic ack_o
);

    logic [31:0] err_run_q;
    logic [31:0] ack_run_q;
    logic [31:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_run_q <= '0;
            ack_run_q <= '0;
            gap_q     <= '0;
            seen_q    <= 1'b0;
        end else begin
            if (!err_s) begin
                err_run_q <= '0;
            end else if (err_run_q < 32'(MIN_ERR_CYCLES)) begin
                err_run_q <= err_run_q + 32'd1;
            end
            if (!ack_o) begin
                ack_run_q <= '0;
            end else if (ack_run_q <= 32'(ACK_CYCLES)) begin
                ack_run_q <= ack_run_q + 32'd1;
            end
            if (ack_o) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else if (gap_q < 32'(MIN_ERR_CYCLES)) begin
                gap_q <= gap_q + 32'd1;
            end
        end
    end

    // R3 R4: a pulse starts only after the full error run has been seen.
    a_r3_threshold_met: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ack_o) |-> (err_run_q >= 32'(MIN_ERR_CYCLES)));

    // R5: every pulse has exactly the configured width.
    a_r5_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ack_o) |-> (ack_run_q == 32'(ACK_CYCLES)));

    // R6: consecutive pulses are separated by at least the holdoff.
    a_r6_holdoff_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(ack_o) && seen_q) |-> (gap_q >= 32'(MIN_ERR_CYCLES)));

    // R8: no pulse in the first cycle after reset release.
    a_r8_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> !ack_o);

endmodule

bind lock_supervisor lsv_checker #(
    .MIN_ERR_CYCLES (MIN_ERR_CYCLES),
    .ACK_CYCLES     (ACK_CYCLES)
) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .err_s  (err_s),
    .ack_o  (ack_o)
);

// File: tb/sim_lock_supervisor.sv
`timescale 1ns/1ps
module sim_lock_supervisor;

    localparam int MIN_E = 12;
    localparam int ACK_W = 3;
    localparam int GAP   = MIN_E + ACK_W + 8;

    logic clk = 1'b0;
    logic rst_n;
    logic sync_err;
    logic ack;
    logic sync_lost;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    int exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lock_supervisor #(
        .MIN_ERR_CYCLES (MIN_E),
        .ACK_CYCLES     (ACK_W)
    ) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sync_err_i  (sync_err),
        .ack_o       (ack),
        .sync_lost_o (sync_lost)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one error burst; expected pulse rise cycles go into the scoreboard.
    task automatic burst(input int n_high, input int n_low);
        int start;
        @(negedge clk);
        sync_err = 1'b1;
        start = cyc;
        for (int k = 0; MIN_E + k * (ACK_W + MIN_E) <= n_high; k++) begin
            exp_q.push_back(start + MIN_E + 2 + k * (ACK_W + MIN_E));
        end
        #0.5;
        check(sync_lost === 1'b1, "R1 loop high", int'(sync_lost), 1);
        repeat (n_high - 1) @(negedge clk);
        @(negedge clk);
        sync_err = 1'b0;
        #0.5;
        check(sync_lost === 1'b0, "R1 loop low", int'(sync_lost), 0);
        repeat (n_low) @(negedge clk);
    endtask

    // Monitor: pops expected rises and checks the timing and width of each pulse.
    logic ack_prev = 1'b0;
    int   rise_c   = 0;
    int   width    = 0;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (ack === 1'b1 && !ack_prev) begin
                rise_c = cyc;
                width  = 0;
            end
            if (ack === 1'b1) width++;
            if (ack !== 1'b1 && ack_prev) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 R7 unexpected pulse", rise_c, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(rise_c == e, "R2 R4 R6 pulse rise cycle", rise_c, e);
                end
                check(width == ACK_W, "R5 pulse width", width, ACK_W);
            end
            ack_prev = (ack === 1'b1);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        sync_err = 1'b1;
        repeat (4) @(negedge clk);
        check(ack === 1'b0, "R8 ack low in reset", int'(ack), 0);
        check(sync_lost === 1'b1, "R1 loop during reset", int'(sync_lost), 1);
        sync_err = 1'b0;
        #0.5;
        check(sync_lost === 1'b0, "R1 loop during reset low", int'(sync_lost), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ack === 1'b0, "R8 ack low after release", int'(ack), 0);
        repeat (3) @(negedge clk);

        burst(MIN_E - 1, GAP);              // R3: one sample short, no pulse
        burst(MIN_E, GAP);                  // R4: exactly the minimum, one pulse
        burst(MIN_E + 1, GAP);              // R5: error clears mid-pulse, full width
        burst(MIN_E - 1, 1);                // R7: one-cycle gap clears the count
        burst(MIN_E - 1, GAP);
        burst(MIN_E + 2 * (ACK_W + MIN_E) + 1, GAP);  // R6: three pulses with holdoff

        repeat (GAP) @(negedge clk);
        check(exp_q.size() == 0, "R4 R6 missing pulses", exp_q.size(), 0);
        check(ack === 1'b0, "R3 idle ack low", int'(ack), 0);
        finish_run();
    end

endmodule